// File: doc/BRIEF.md
# Event and Semaphore Aliased Register Bank

This block is a memory-mapped bank of 256 single-bit event flags and 256 thirty-two-bit semaphore counters inside a 1 MiB address region. Software and engines use it as a shared synchronisation plane. A producer raises an event or bumps a counter, and a consumer polls the same location.

The operation is not carried in a command field. The address window chosen by the access selects it. The semaphore array appears four times in the map. One window is a plain view. A write there does nothing. A second window overwrites the counter. A third adds the written value and a fourth subtracts it, and both of those saturate instead of wrapping. In every window the counter index comes from address bits [9:2]. Each event is also driven out on its own level output.

The bus is a simple single-beat register port. A request is presented for one cycle with `bus_sel` high. One cycle later `bus_ready` pulses and `bus_rdata` carries the read result. A new request may be issued in every cycle.

Top module: `evsem_bank`

## Requirements
- R1: After reset every event flag and every counter is zero, and `bus_ready` and `bus_rdata` are low.
- R2: `bus_ready` is high in exactly the cycle after each cycle with `bus_sel` high, and low in all other cycles. `bus_rdata` is valid in that cycle.
- R3: The event window covers byte offsets 0x000 to 0x3FF, and the event index is address bits [9:2]. A write sets the indexed flag to `bus_wdata[0]`. A read returns the flag in bit 0, with zeros above it. `evt_level[i]` always shows flag i, and a write is visible on it from the cycle after the request.
- R4: The plain semaphore window covers 0x1000 to 0x13FF. A read returns the indexed counter. A write there leaves every counter unchanged.
- R5: The overwrite window covers 0x1400 to 0x17FF. A write stores `bus_wdata` into the indexed counter.
- R6: The add window covers 0x1800 to 0x1BFF. A write adds `bus_wdata` to the indexed counter. If the true sum exceeds 0xFFFFFFFF, the counter becomes 0xFFFFFFFF.
- R7: The subtract window covers 0x1C00 to 0x1FFF. A write subtracts `bus_wdata` from the indexed counter. If `bus_wdata` is larger than the counter, the counter becomes 0.
- R8: A read of the overwrite, add or subtract window returns the indexed counter and does not change it.
- R9: Any address whose bits [19:10] are not 0, 4, 5, 6 or 7 reads as zero. A write to such an address changes no flag and no counter.
- R10: `bus_rdata` is zero in the response cycle of a write. Address bits [1:0] have no effect.
- R11: A write is seen by a read of the same index issued in the next cycle, through any window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Request strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 20 | Byte address within the 1 MiB region |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high |
| bus_ready | output | 1 | Response strobe, the cycle after the request |
| evt_level | output | 256 | Level output of each event flag |

## Verification
A write's update and the read issued in the next cycle meet at the same clock edge. At that edge the counter or flag changes while the following request already selects the same entry through another alias. The bench provokes this with back-to-back request sequences on one index: an add then a read of the plain view, a subtract then a read of the add window, and an event write then an event read. These sequences run at the saturation limits as well as at ordinary values. A behavioural model updates its arrays when each request is issued. It predicts the response of every cycle, which confirms that the read sees the new value and never the old one, and it checks the event levels in the same cycles.

// File: rtl/evsem_bank.sv
module evsem_bank #(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 32,
  parameter int N_ENT    = 256,
  parameter int EVT_OFF  = 'h0000,
  parameter int SRD_OFF  = 'h1000,
  parameter int SSET_OFF = 'h1400,
  parameter int SINC_OFF = 'h1800,
  parameter int SDEC_OFF = 'h1C00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic [N_ENT-1:0]  evt_level
);
  localparam int IDX_W = $clog2(N_ENT);
  localparam int WIN_LSB = IDX_W + 2;
  localparam int WIN_W = ADDR_W - WIN_LSB;
  localparam logic [WIN_W-1:0] W_EVT  = WIN_W'(EVT_OFF  >> WIN_LSB);
  localparam logic [WIN_W-1:0] W_SRD  = WIN_W'(SRD_OFF  >> WIN_LSB);
  localparam logic [WIN_W-1:0] W_SSET = WIN_W'(SSET_OFF >> WIN_LSB);
  localparam logic [WIN_W-1:0] W_SINC = WIN_W'(SINC_OFF >> WIN_LSB);
  localparam logic [WIN_W-1:0] W_SDEC = WIN_W'(SDEC_OFF >> WIN_LSB);

  logic [DATA_W-1:0] sem [N_ENT];
  logic [N_ENT-1:0]  evt;
  logic [DATA_W-1:0] rd_mux;

  wire [WIN_W-1:0] win = bus_addr[ADDR_W-1:WIN_LSB];
  wire [IDX_W-1:0] idx = bus_addr[WIN_LSB-1:2];
  wire unused_lsb = ^bus_addr[1:0];

  wire hit_evt = (win == W_EVT);
  wire hit_sem = (win == W_SRD) || (win == W_SSET) || (win == W_SINC) || (win == W_SDEC);
  wire do_wr   = bus_sel && bus_we;

  wire [DATA_W-1:0] cur = sem[idx];
  wire [DATA_W:0]   sum = {1'b0, cur} + {1'b0, bus_wdata};
  wire [DATA_W-1:0] inc_v = sum[DATA_W] ? {DATA_W{1'b1}} : sum[DATA_W-1:0];
  wire [DATA_W-1:0] dec_v = (bus_wdata > cur) ? '0 : cur - bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt <= '0;
      for (int i = 0; i < N_ENT; i++) sem[i] <= '0;
    end else if (do_wr) begin
      if (hit_evt) evt[idx] <= bus_wdata[0];
      else if (win == W_SSET) sem[idx] <= bus_wdata;
      else if (win == W_SINC) sem[idx] <= inc_v;
      else if (win == W_SDEC) sem[idx] <= dec_v;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_evt) rd_mux = {{(DATA_W-1){1'b0}}, evt[idx]};
    else if (hit_sem) rd_mux = cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_sel;
      bus_rdata <= (bus_sel && !bus_we) ? rd_mux : '0;
    end
  end

  assign evt_level = evt;
endmodule

// File: rtl/evsem_bank_chk.sv
module evsem_bank_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int N_ENT  = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_ready,
  input logic [N_ENT-1:0]  evt_level
);
  localparam int IDX_W = $clog2(N_ENT);
  localparam int WIN_LSB = IDX_W + 2;
  wire [ADDR_W-WIN_LSB-1:0] win = bus_addr[ADDR_W-1:WIN_LSB];
  wire [IDX_W-1:0] idx = bus_addr[WIN_LSB-1:2];
  wire in_evt = (win == 0);
  wire outside = !(in_evt || (win >= 4 && win <= 7));

  AST_READY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> bus_ready); // R2
  AST_READY_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !bus_ready); // R2
  AST_WRITE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we) |=> (bus_rdata == '0)); // R10
  AST_OUTSIDE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && outside) |=> (bus_rdata == '0)); // R9
  AST_EVT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && in_evt) |=> (evt_level[$past(idx)] == $past(bus_wdata[0]))); // R3
  AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we && in_evt) |=> $stable(evt_level)); // R9
  AST_EVT_READ_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && in_evt) |=> (bus_rdata[DATA_W-1:1] == '0)); // R3
endmodule

bind evsem_bank evsem_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_ENT(N_ENT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready), .evt_level(evt_level)
);

// File: tb/evsem_bank_test.sv
`timescale 1ns/1ps
module evsem_bank_test;
  logic clk = 0, rst_n = 0;
  logic sel = 0, we = 0;
  logic [19:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic ready;
  logic [255:0] evt_level;

  evsem_bank uut (.clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_ready(ready), .evt_level(evt_level));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [255:0] evt_m = '0;
  logic [31:0] sem_m [256];
  logic exp_ready = 0;
  logic [31:0] exp_rdata = 0;
  string exp_tag = "R1";

  task automatic chk(string tag, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit s, bit w, logic [19:0] a, logic [31:0] d, string tag);
    int win, ix;
    longint t;
    @(negedge clk);
    chk("R2", "ready", 256'(ready), 256'(exp_ready));
    if (exp_ready) chk(exp_tag, "rdata", 256'(rdata), 256'(exp_rdata));
    chk(exp_tag, "evt_level", evt_level, evt_m);
    win = int'(a >> 10);
    ix = int'((a >> 2) & 20'hFF);
    exp_ready = s;
    exp_tag = tag;
    exp_rdata = 0;
    if (s && !w) begin
      if (win == 0) exp_rdata = {31'b0, evt_m[ix]};
      else if (win >= 4 && win <= 7) exp_rdata = sem_m[ix];
    end
    if (s && w) begin
      if (win == 0) evt_m[ix] = d[0];
      else if (win == 5) sem_m[ix] = d;
      else if (win == 6) begin
        t = longint'(sem_m[ix]) + longint'(d);
        sem_m[ix] = (t > 64'hFFFFFFFF) ? 32'hFFFFFFFF : t[31:0];
      end else if (win == 7) sem_m[ix] = (d > sem_m[ix]) ? 32'h0 : sem_m[ix] - d;
    end
    sel = s; we = w; addr = a; wdata = d;
  endtask

  task automatic rd(logic [19:0] a, string tag); cyc(1, 0, a, 0, tag); endtask
  task automatic wr(logic [19:0] a, logic [31:0] d, string tag); cyc(1, 1, a, d, tag); endtask
  task automatic idle(); cyc(0, 0, 0, 0, "R2"); endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) sem_m[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1", "ready", 256'(ready), 0);
    chk("R1", "rdata", 256'(rdata), 0);
    chk("R1", "evt_level", evt_level, 0);
    rst_n = 1;
    rd(20'h1000, "R1"); rd(20'h13FC, "R1"); rd(20'h0000, "R1"); rd(20'h03FC, "R1");
    idle();
    // events at both index limits and in the middle
    wr(20'h0000, 1, "R3"); wr(20'h03FC, 32'hFFFF_FFFF, "R3"); wr(20'h0200, 3, "R3");
    rd(20'h0000, "R3"); rd(20'h03FC, "R3"); rd(20'h0200, "R3"); rd(20'h0204, "R3");
    wr(20'h0200, 2, "R3"); rd(20'h0200, "R11");
    idle();
    // overwrite window and reads through all four aliases
    wr(20'h1400, 32'h1234_5678, "R5"); wr(20'h17FC, 32'hA5A5_0001, "R5");
    rd(20'h1000, "R4"); rd(20'h1400, "R8"); rd(20'h1800, "R8"); rd(20'h1C00, "R8");
    rd(20'h13FC, "R4"); rd(20'h1BFC, "R8"); rd(20'h1FFC, "R8"); rd(20'h1000, "R8");
    // writes to the plain view are ignored
    wr(20'h1000, 32'hDEAD_BEEF, "R4"); rd(20'h1000, "R4");
    // add, normal then saturating, with back-to-back reads
    wr(20'h1804, 10, "R6"); rd(20'h1004, "R11");
    wr(20'h1804, 32'h7FFF_FFFF, "R6"); rd(20'h1C04, "R11");
    wr(20'h1404, 32'hFFFF_FFF0, "R5"); wr(20'h1804, 32'h100, "R6"); rd(20'h1004, "R6");
    wr(20'h1804, 0, "R6"); rd(20'h1404, "R6");
    wr(20'h1408, 32'hFFFF_FFFE, "R5"); wr(20'h1808, 1, "R6"); rd(20'h1008, "R6");
    wr(20'h1808, 1, "R6"); rd(20'h1008, "R6");
    // subtract, normal then saturating
    wr(20'h140C, 100, "R5"); wr(20'h1C0C, 40, "R7"); rd(20'h180C, "R11");
    wr(20'h1C0C, 60, "R7"); rd(20'h100C, "R7");
    wr(20'h140C, 5, "R5"); wr(20'h1C0C, 6, "R7"); rd(20'h100C, "R7");
    wr(20'h1C0C, 32'hFFFF_FFFF, "R7"); rd(20'h100C, "R7");
    idle();
    // outside the windows
    rd(20'h0400, "R9"); rd(20'h0FFC, "R9"); rd(20'h2000, "R9"); rd(20'hFFFFC, "R9");
    wr(20'h0400, 1, "R9"); wr(20'h2004, 32'h55, "R9"); wr(20'hFFFFC, 32'h77, "R9");
    wr(20'h0C00, 1, "R9");
    rd(20'h0000, "R9"); rd(20'h1004, "R9"); rd(20'h1000, "R9");
    // address low bits ignored
    wr(20'h1413, 32'h0BAD_F00D, "R10"); rd(20'h1012, "R10"); rd(20'h1011, "R10");
    wr(20'h0011, 1, "R10"); rd(20'h0013, "R10");
    idle();
    // fill all counters and events, then sample them
    for (int i = 0; i < 256; i++) wr(20'h1400 + 20'(i*4), 32'(i*3 + 1), "R5");
    for (int i = 0; i < 256; i++) wr(20'h0000 + 20'(i*4), 32'(i % 3 == 0), "R3");
    for (int i = 0; i < 256; i += 17) begin
      rd(20'h1000 + 20'(i*4), "R4");
      rd(20'h0000 + 20'(i*4), "R3");
    end
    for (int i = 0; i < 256; i += 31) begin
      wr(20'h1800 + 20'(i*4), 32'(i), "R6");
      rd(20'h1C00 + 20'(i*4), "R11");
      wr(20'h1C00 + 20'(i*4), 32'(i*5), "R7");
      rd(20'h1800 + 20'(i*4), "R11");
    end
    idle(); idle(); idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule